// File: doc/BRIEF.md
# Real-Time Clock Event Flag and Oscillator-Fail Status Block

This block holds the status and configuration state that a real-time clock reports to its host. The time counters send one-cycle rollover strobes, and the block latches each one into a flag that stays set until the host reads the flag register. An oscillator-failure flag is set at power-up and on every failure the oscillator detector reports. That flag stays set until the host writes the clock start bit while the oscillator is running.

The same byte location holds two configuration bits. Bit 6 has two meanings. A read of bit 6 returns the failure flag, while a write to bit 6 stores the supply-mode selection. Bit 7 enables the test register. A second byte location holds a five-bit routing mask. The mask sends each of five interrupt sources either to the main interrupt output or to the multi-function output.

Host access uses a simple byte bus. The bus has an address, one-cycle read and write strobes, write data and combinational read data. The clock start/stop bit belongs to a neighbouring register. Its write arrives here as a separate strobe, together with a level that shows whether the oscillator is running.

Top module: `rtc_status_regs`

## Requirements
- R1: After power-on reset (rstN low), the flag register (address 0) reads 0x40, singleSupply is 1, testEnable is 0, the routing register (address 1) reads 0x00, and mfoOut and intrOut are 0.
- R2: A one on rollStb[i] sets flag register bit i (bits 5:0). From the next cycle that bit reads as one, and it stays one until the flag register is read.
- R3: A read of the flag register (regRd high with regAddr 0) returns the current flags and clears bits 5:0 from the next cycle. If a strobe arrives in the same cycle as the read, its flag reads as one on the following read.
- R4: A write to the flag register leaves bits 5:0 unchanged.
- R5: Bit 6 of a flag-register read returns the oscillator-fail flag. A one on oscFailDet sets this flag. Reads, writes and rollover strobes leave it unchanged.
- R6: The fail flag clears only when clkStartWr is high while oscRunning is high. clkStartWr with oscRunning low has no effect. If oscFailDet is high in the same cycle, the flag stays set.
- R7: A write to the flag register loads singleSupply from write-data bit 6. oscFailDet forces singleSupply to 1.
- R8: A write to the flag register loads testEnable from write-data bit 7. Flag-register reads return testEnable in bit 7.
- R9: The routing register at address 1 stores write-data bits 4:0 and reads them back. Bits 7:5 of this register read as zero.
- R10: One cycle after irqSrc changes, mfoOut equals the OR of the sources whose routing bit is 1. In the same cycle, intrOut equals the OR of the sources whose routing bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| rollStb | input | 6 | Rollover strobes from the time counters |
| oscFailDet | input | 1 | Oscillator failure detected |
| clkStartWr | input | 1 | A one is being written to the clock start bit |
| oscRunning | input | 1 | Oscillator is running |
| irqSrc | input | 5 | Interrupt source levels |
| regAddr | input | 2 | Register address (0 flags, 1 routing) |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed register |
| singleSupply | output | 1 | Supply-mode configuration bit (1 means single supply) |
| testEnable | output | 1 | Test register enable |
| mfoOut | output | 1 | Multi-function interrupt output |
| intrOut | output | 1 | Main interrupt output |

## Verification
A flag that is lost or stuck first shows on the next read of address 0. A read-clear that misses a strobe arriving in the same cycle shows on the read after that. A fail flag that clears under the wrong condition shows at bit 6 within one read. Routing faults show on mfoOut or intrOut one cycle after irqSrc changes. The bench therefore reads the flag register right after each stimulus, and it samples the interrupt outputs on the first cycle after each change.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic clrEvents;
    logic wrCfg;
    logic wrRoute;
    logic clrFail;
    logic selFlag;
    logic selRoute;
  } ctlStrobes_t;
endpackage

// File: rtl/rtc_stat_ctrl.sv
module rtc_stat_ctrl
  import rtc_stat_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int ADDR_FLAG  = 0,
  parameter int ADDR_ROUTE = 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              clkStartWr,
  input  logic              oscRunning,
  output ctlStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] FLAG_A  = ADDR_W'(ADDR_FLAG);
  localparam logic [ADDR_W-1:0] ROUTE_A = ADDR_W'(ADDR_ROUTE);

  always_comb begin
    strobes.selFlag   = (regAddr == FLAG_A);
    strobes.selRoute  = (regAddr == ROUTE_A);
    strobes.clrEvents = regRd && strobes.selFlag;
    strobes.wrCfg     = regWr && strobes.selFlag;
    strobes.wrRoute   = regWr && strobes.selRoute;
    strobes.clrFail   = clkStartWr && oscRunning;
  end
endmodule

// File: rtl/rtc_stat_dpath.sv
module rtc_stat_dpath
  import rtc_stat_pkg::*;
#(
  parameter int NUM_EVENTS = 6,
  parameter int NUM_IRQ    = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [NUM_EVENTS-1:0] rollStb,
  input  logic                  oscFailDet,
  input  logic [NUM_IRQ-1:0]    irqSrc,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic [NUM_EVENTS-1:0] eventFlags,
  output logic                  oscFail,
  output logic                  singleSupply,
  output logic                  testEnable,
  output logic                  mfoOut,
  output logic                  intrOut
);
  localparam int FAIL_BIT = NUM_EVENTS;
  localparam int TEST_BIT = NUM_EVENTS + 1;

  logic [NUM_IRQ-1:0] routeMask;

  for (genvar i = 0; i < NUM_EVENTS; i++) begin : gEvt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        eventFlags[i] <= 1'b0;
      else if (rollStb[i])
        eventFlags[i] <= 1'b1;
      else if (strobes.clrEvents)
        eventFlags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscFail      <= 1'b1;
      singleSupply <= 1'b1;
      testEnable   <= 1'b0;
      routeMask    <= '0;
    end else begin
      if (oscFailDet)
        oscFail <= 1'b1;
      else if (strobes.clrFail)
        oscFail <= 1'b0;
      if (oscFailDet)
        singleSupply <= 1'b1;
      else if (strobes.wrCfg)
        singleSupply <= regWdata[FAIL_BIT];
      if (strobes.wrCfg)
        testEnable <= regWdata[TEST_BIT];
      if (strobes.wrRoute)
        routeMask <= regWdata[NUM_IRQ-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mfoOut  <= 1'b0;
      intrOut <= 1'b0;
    end else begin
      mfoOut  <= |(irqSrc & routeMask);
      intrOut <= |(irqSrc & ~routeMask);
    end
  end

  always_comb begin
    regRdata = '0;
    if (strobes.selFlag) begin
      regRdata[NUM_EVENTS-1:0] = eventFlags;
      regRdata[FAIL_BIT]       = oscFail;
      regRdata[TEST_BIT]       = testEnable;
    end else if (strobes.selRoute) begin
      regRdata[NUM_IRQ-1:0] = routeMask;
    end
  end
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_stat_pkg::*;
#(
  parameter int NUM_EVENTS = 6,
  parameter int NUM_IRQ    = 5,
  parameter int ADDR_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] rollStb,
  input  logic                  oscFailDet,
  input  logic                  clkStartWr,
  input  logic                  oscRunning,
  input  logic [NUM_IRQ-1:0]    irqSrc,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  singleSupply,
  output logic                  testEnable,
  output logic                  mfoOut,
  output logic                  intrOut
);
  ctlStrobes_t           strobes;
  logic [NUM_EVENTS-1:0] eventFlags;
  logic                  oscFail;

  rtc_stat_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .clkStartWr(clkStartWr), .oscRunning(oscRunning), .strobes(strobes)
  );

  rtc_stat_dpath #(.NUM_EVENTS(NUM_EVENTS), .NUM_IRQ(NUM_IRQ)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rollStb(rollStb),
    .oscFailDet(oscFailDet), .irqSrc(irqSrc), .regWdata(regWdata),
    .regRdata(regRdata), .eventFlags(eventFlags), .oscFail(oscFail),
    .singleSupply(singleSupply), .testEnable(testEnable),
    .mfoOut(mfoOut), .intrOut(intrOut)
  );
endmodule

// File: rtl/rtc_stat_chk.sv
module rtc_stat_chk #(
  parameter int NUM_EVENTS = 6,
  parameter int NUM_IRQ    = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_EVENTS-1:0] rollStb,
  input logic                  oscFailDet,
  input logic                  clkStartWr,
  input logic                  oscRunning,
  input logic [NUM_IRQ-1:0]    irqSrc,
  input logic [NUM_EVENTS-1:0] eventFlags,
  input logic                  oscFail,
  input logic                  singleSupply,
  input logic                  mfoOut,
  input logic                  intrOut,
  input logic                  clrEvents
);
  AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (rollStb != '0) |=> ((eventFlags & $past(rollStb)) == $past(rollStb))); // R2

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvents && rollStb == '0) |=> (eventFlags == '0)); // R3

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!clrEvents) |=> ((eventFlags & $past(eventFlags)) == $past(eventFlags))); // R2

  AST_FAIL_SET: assert property (@(posedge clk) disable iff (!rstN)
    oscFailDet |=> (oscFail && singleSupply)); // R5

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (oscFail && !(clkStartWr && oscRunning)) |=> oscFail); // R6

  AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clkStartWr && oscRunning && !oscFailDet) |=> !oscFail); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (irqSrc == '0) |=> (!mfoOut && !intrOut)); // R10
endmodule

bind rtc_status_regs rtc_stat_chk #(.NUM_EVENTS(NUM_EVENTS), .NUM_IRQ(NUM_IRQ)) uChk (
  .clk(clk), .rstN(rstN), .rollStb(rollStb), .oscFailDet(oscFailDet),
  .clkStartWr(clkStartWr), .oscRunning(oscRunning), .irqSrc(irqSrc),
  .eventFlags(eventFlags), .oscFail(oscFail), .singleSupply(singleSupply),
  .mfoOut(mfoOut), .intrOut(intrOut), .clrEvents(strobes.clrEvents)
);

// File: tb/sim_rtc_status_regs.sv
`timescale 1ns/1ps
module sim_rtc_status_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] rollStb = '0;
  logic       oscFailDet = 1'b0;
  logic       clkStartWr = 1'b0;
  logic       oscRunning = 1'b0;
  logic [4:0] irqSrc = '0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       singleSupply, testEnable, mfoOut, intrOut;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtc_status_regs u0 (
    .clk(clk), .rstN(rstN), .rollStb(rollStb), .oscFailDet(oscFailDet),
    .clkStartWr(clkStartWr), .oscRunning(oscRunning), .irqSrc(irqSrc),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .singleSupply(singleSupply), .testEnable(testEnable),
    .mfoOut(mfoOut), .intrOut(intrOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [1:0] a, input logic [5:0] stb, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1; rollStb = stb;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0; rollStb = '0;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] w);
    @(negedge clk);
    regAddr = a; regWdata = w; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic pulseStart(input logic running, input logic fail);
    @(negedge clk);
    clkStartWr = 1'b1; oscRunning = running; oscFailDet = fail;
    @(negedge clk);
    clkStartWr = 1'b0; oscFailDet = 1'b0;
  endtask

  task automatic pulseRoll(input logic [5:0] stb);
    @(negedge clk);
    rollStb = stb;
    @(negedge clk);
    rollStb = '0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 singleSupply", {7'b0, singleSupply}, 8'h01);
    check("R1 testEnable", {7'b0, testEnable}, 8'h00);
    check("R1 irq outputs", {6'b0, mfoOut, intrOut}, 8'h00);
    doRead(2'd0, 6'b0, d); check("R1 flag reg", d, 8'h40);
    doRead(2'd1, 6'b0, d); check("R1 route reg", d, 8'h00);
  endtask

  task automatic testFailClear();
    logic [7:0] d;
    pulseStart(1'b0, 1'b0);
    doRead(2'd0, 6'b0, d); check("R6 start without osc", d, 8'h40);
    pulseStart(1'b1, 1'b1);
    doRead(2'd0, 6'b0, d); check("R6 detect beats clear", d, 8'h40);
    pulseStart(1'b1, 1'b0);
    doRead(2'd0, 6'b0, d); check("R6 clear with osc", d, 8'h00);
  endtask

  task automatic testEvents();
    logic [7:0] d;
    pulseRoll(6'b000101);
    repeat (3) @(negedge clk);
    doRead(2'd0, 6'b0, d); check("R2 flags held", d, 8'h05);
    doRead(2'd0, 6'b0, d); check("R3 read clears", d, 8'h00);
    pulseRoll(6'b000010);
    doRead(2'd0, 6'b100000, d); check("R3 read before collision", d, 8'h02);
    doRead(2'd0, 6'b0, d); check("R3 collision kept", d, 8'h20);
    pulseRoll(6'b000001);
    doRead(2'd1, 6'b0, d);
    doRead(2'd0, 6'b0, d); check("R3 route read no clear", d, 8'h01);
  endtask

  task automatic testConfig();
    logic [7:0] d;
    doWrite(2'd0, 8'hFF);
    doRead(2'd0, 6'b0, d); check("R4 R8 write ignored bits", d, 8'h80);
    check("R7 singleSupply set", {7'b0, singleSupply}, 8'h01);
    check("R8 testEnable set", {7'b0, testEnable}, 8'h01);
    doWrite(2'd0, 8'h00);
    check("R7 singleSupply cleared", {7'b0, singleSupply}, 8'h00);
    check("R8 testEnable cleared", {7'b0, testEnable}, 8'h00);
    doRead(2'd0, 6'b0, d); check("R5 fail unaffected by write", d, 8'h00);
    @(negedge clk); oscFailDet = 1'b1;
    @(negedge clk); oscFailDet = 1'b0;
    check("R7 fail forces single", {7'b0, singleSupply}, 8'h01);
    doRead(2'd0, 6'b0, d); check("R5 fail set", d, 8'h40);
    pulseStart(1'b1, 1'b0);
  endtask

  task automatic testRoute();
    logic [7:0] d;
    doWrite(2'd1, 8'hFF);
    doRead(2'd1, 6'b0, d); check("R9 route upper zero", d, 8'h1F);
    doWrite(2'd1, 8'h05);
    doRead(2'd1, 6'b0, d); check("R9 route readback", d, 8'h05);
    @(negedge clk); irqSrc = 5'b00100;
    @(negedge clk); check("R10 to mfo", {6'b0, mfoOut, intrOut}, 8'h02);
    irqSrc = 5'b01000;
    @(negedge clk); check("R10 to intr", {6'b0, mfoOut, intrOut}, 8'h01);
    irqSrc = 5'b11111;
    @(negedge clk); check("R10 both", {6'b0, mfoOut, intrOut}, 8'h03);
    irqSrc = 5'b00000;
    @(negedge clk); check("R10 none", {6'b0, mfoOut, intrOut}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFailClear();
    testEvents();
    testConfig();
    testRoute();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule